// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This unit records when an external event happens, measured against a free-running 16-bit counter that the surrounding timer supplies. A select input picks the event source: a dedicated capture pin or a second input that is typically driven by an on-chip comparator. The chosen input is brought into the clock domain by a two-stage synchronizer. An edge detector then looks for either rising or falling transitions, as set by a polarity input. On each detected transition the current counter value is stored in a stamp register, and a pending flag is raised in the same clock cycle.

The pending flag drives an interrupt request whenever the interrupt enable is high. There are two ways to clear the flag. The interrupt controller can pulse an acknowledge input when the handler runs, or software can write a one to the flag bit. The CPU can also load the stamp register directly. This lets the neighbouring counter logic use the register as the TOP value for clear-on-match counting. Software computes frequency or duty cycle from successive stamps.

Top module: `evt_stamp_unit`

## Requirements
- R1: A detected event loads the full counter value `cnt_i`, as sampled at that clock edge, into `stamp_o`.
- R2: The pending flag `flag_o` rises at the same clock edge that loads the new stamp.
- R3: `irq_o` is high after a clock edge exactly when the flag is set and `irq_en_i` was high at that edge. With the enable low, a set flag raises no request.
- R4: A pulse on `irq_ack_i` clears the flag at the next clock edge.
- R5: A flag write (`flag_wr_i` = 1) with `flag_wdata_i` = 1 clears the flag. A flag write with `flag_wdata_i` = 0 leaves the flag unchanged.
- R6: With `src_alt_i` = 0 the capture pin is the event source and transitions on the alternate input are ignored. With `src_alt_i` = 1 the roles swap.
- R7: A CPU write (`top_wr_i` = 1) loads `top_wdata_i` into `stamp_o` at the next clock edge. With no write and no event, `stamp_o` holds its value.
- R8: With `edge_rise_i` = 1 only 0-to-1 transitions are events, and with 0 only 1-to-0 transitions are events. Each transition gives exactly one capture, at the third rising clock edge after the input changes (two synchronizer stages plus one detect stage).
- R9: An event that arrives while the flag is already set overwrites `stamp_o` with the new counter value, and the flag stays set.
- R10: When an event and a CPU write, an acknowledge or a flag clear fall in the same cycle, the event wins: the counter value is stored and the flag ends up set.
- R11: Synchronous reset clears `stamp_o`, `flag_o` and `irq_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Running counter value to timestamp against |
| cap_pin_i | input | 1 | Dedicated capture pin (asynchronous) |
| cap_alt_i | input | 1 | Alternate event input, e.g. a comparator output (asynchronous) |
| src_alt_i | input | 1 | Source select: 0 pin, 1 alternate input |
| edge_rise_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| irq_en_i | input | 1 | Interrupt enable |
| top_wr_i | input | 1 | CPU write strobe for the stamp register |
| top_wdata_i | input | 16 | CPU write data for the stamp register |
| flag_wr_i | input | 1 | CPU write strobe for the flag bit |
| flag_wdata_i | input | 1 | Flag bit data; writing 1 clears the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| stamp_o | output | 16 | Stamp register (captured time or CPU-loaded TOP) |
| flag_o | output | 1 | Capture pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs. The polarity input stays steady while an edge is in the synchronizer. The source select changes only while both event inputs are at the same level, because a switch between inputs at different levels looks like a transition. The stimulus respects both rules. It changes polarity only in an idle setup cycle before an input moves, and it leaves the source select alone whenever the pin and the alternate input differ. Each random step lines up the CPU write, acknowledge or flag write with the capture cycle, so that the same-cycle precedence cases come up often.

// File: rtl/evs_pkg.sv
package evs_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_ALT = 1'b1
  } src_pick_e;

  localparam int unsigned SRC_COUNT = 2;
endpackage

// File: rtl/evs_sync.sv
module evs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/evs_edge_det.sv
module evs_edge_det
  import evs_pkg::*;
#(
  parameter int unsigned SRC_N = SRC_COUNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] sync_i,
  input  logic             src_alt_i,
  input  logic             edge_rise_i,
  output logic             evt_o
);
  src_pick_e  pick;
  edge_mode_e mode;
  logic       cur;
  logic       prev_q;

  assign pick = src_pick_e'(src_alt_i);
  assign mode = edge_mode_e'(edge_rise_i);
  assign cur  = (pick == SRC_ALT) ? sync_i[1] : sync_i[0];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  always_comb begin
    if (mode == EDGE_RISE) evt_o = cur & ~prev_q;
    else                   evt_o = ~cur & prev_q;
  end
endmodule

// File: rtl/evs_cap_reg.sv
module evs_cap_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_evt_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cpu_wr_i,
  input  logic [W-1:0] cpu_data_i,
  input  logic         clr_wr_i,
  input  logic         clr_bit_i,
  input  logic         ack_i,
  input  logic         irq_en_i,
  output logic [W-1:0] val_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic flag_d;
  logic clr_req;

  assign clr_req = ack_i | (clr_wr_i & clr_bit_i);

  always_comb begin
    if (cap_evt_i)    flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o  <= '0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (cap_evt_i)     val_o <= cnt_i;
      else if (cpu_wr_i) val_o <= cpu_data_i;
      flag_o <= flag_d;
      irq_o  <= flag_d & irq_en_i;
    end
  end

  AST_CAP_COPIES: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> (val_o == $past(cnt_i))); // R1
  AST_FLAG_WITH_VALUE: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> flag_o); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (flag_o && $past(irq_en_i)))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !cap_evt_i) |=> !flag_o); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && clr_bit_i && !cap_evt_i) |=> !flag_o); // R5
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && !clr_bit_i && !ack_i && flag_o) |=> flag_o); // R5
  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_i && !cap_evt_i) |=> (val_o == $past(cpu_data_i))); // R7
  AST_VAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cap_evt_i && !cpu_wr_i) |=> $stable(val_o)); // R7
  AST_CAP_BEATS_WR: assert property (@(posedge clk) disable iff (rst)
    (cap_evt_i && (cpu_wr_i || clr_req)) |=> (flag_o && val_o == $past(cnt_i))); // R10
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
  import evs_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_pin_i,
  input  logic             cap_alt_i,
  input  logic             src_alt_i,
  input  logic             edge_rise_i,
  input  logic             irq_en_i,
  input  logic             top_wr_i,
  input  logic [CNT_W-1:0] top_wdata_i,
  input  logic             flag_wr_i,
  input  logic             flag_wdata_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] stamp_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam int unsigned SRC_N = SRC_COUNT;

  logic [SRC_N-1:0] raw_src;
  logic [SRC_N-1:0] sync_src;
  logic             cap_evt;

  assign raw_src = {cap_alt_i, cap_pin_i};

  evs_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_src),
    .q_o (sync_src)
  );

  evs_edge_det #(.SRC_N(SRC_N)) edge_i (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (sync_src),
    .src_alt_i   (src_alt_i),
    .edge_rise_i (edge_rise_i),
    .evt_o       (cap_evt)
  );

  evs_cap_reg #(.W(CNT_W)) reg_i (
    .clk        (clk),
    .rst        (rst),
    .cap_evt_i  (cap_evt),
    .cnt_i      (cnt_i),
    .cpu_wr_i   (top_wr_i),
    .cpu_data_i (top_wdata_i),
    .clr_wr_i   (flag_wr_i),
    .clr_bit_i  (flag_wdata_i),
    .ack_i      (irq_ack_i),
    .irq_en_i   (irq_en_i),
    .val_o      (stamp_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o); // R3
endmodule

// File: tb/evt_stamp_unit_tb.sv
module evt_stamp_unit_tb_top;
  localparam int W = 16;
  localparam int OP_NONE = 0, OP_CPUWR = 1, OP_ACK = 2, OP_W1C1 = 3, OP_W1C0 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] cnt_i = '0, top_wdata_i = '0;
  logic cap_pin_i = 0, cap_alt_i = 0, src_alt_i = 0, edge_rise_i = 1, irq_en_i = 0;
  logic top_wr_i = 0, flag_wr_i = 0, flag_wdata_i = 0, irq_ack_i = 0;
  logic [W-1:0] stamp_o;
  logic flag_o, irq_o;

  evt_stamp_unit #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .cap_pin_i(cap_pin_i), .cap_alt_i(cap_alt_i),
    .src_alt_i(src_alt_i), .edge_rise_i(edge_rise_i), .irq_en_i(irq_en_i),
    .top_wr_i(top_wr_i), .top_wdata_i(top_wdata_i), .flag_wr_i(flag_wr_i),
    .flag_wdata_i(flag_wdata_i), .irq_ack_i(irq_ack_i),
    .stamp_o(stamp_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_val = '0;
  logic m_flag = 0, m_irq = 0;
  logic lvl_pin = 0, lvl_alt = 0;

  function automatic logic [W-1:0] next_val(logic cap, int op, logic [W-1:0] cnt,
                                             logic [W-1:0] wd, logic [W-1:0] cur);
    if (cap) return cnt;             // R1, R10
    if (op == OP_CPUWR) return wd;   // R7
    return cur;
  endfunction

  function automatic logic next_flag(logic cap, int op, logic cur);
    if (cap) return 1'b1;                                // R2, R9
    if (op == OP_ACK || op == OP_W1C1) return 1'b0;      // R4, R5
    return cur;
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit sel, input bit emode, input bit en, input bit on_alt,
                      input bit fire, input int op, input string req);
    logic cap;
    logic [W-1:0] wd;
    @(negedge clk);
    if (lvl_pin == lvl_alt) src_alt_i = sel;
    edge_rise_i = emode;
    irq_en_i = en;
    cnt_i = W'($urandom);
    @(negedge clk);
    cnt_i = W'($urandom);
    cap = 1'b0;
    if (fire) begin
      if (on_alt) begin
        lvl_alt = ~lvl_alt; cap_alt_i = lvl_alt;
        cap = (src_alt_i == 1'b1) && (lvl_alt == emode);
      end else begin
        lvl_pin = ~lvl_pin; cap_pin_i = lvl_pin;
        cap = (src_alt_i == 1'b0) && (lvl_pin == emode);
      end
    end
    @(negedge clk);
    cnt_i = W'($urandom);
    @(negedge clk);
    cnt_i = W'($urandom);
    wd = W'($urandom);
    top_wdata_i = wd;
    top_wr_i = (op == OP_CPUWR);
    irq_ack_i = (op == OP_ACK);
    flag_wr_i = (op == OP_W1C1) || (op == OP_W1C0);
    flag_wdata_i = (op == OP_W1C1);
    m_val = next_val(cap, op, cnt_i, wd, m_val);
    m_flag = next_flag(cap, op, m_flag);
    m_irq = m_flag & en;
    @(negedge clk);
    top_wr_i = 0; irq_ack_i = 0; flag_wr_i = 0; flag_wdata_i = 0;
    chk(req, "stamp", stamp_o, m_val);
    chk(req, "flag", W'(flag_o), W'(m_flag));
    chk(req, "irq", W'(irq_o), W'(m_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    cnt_i = 16'h1111;
    @(negedge clk);
    // R11: reset state, checked while reset is still asserted
    chk("R11", "stamp", stamp_o, '0);
    chk("R11", "flag", W'(flag_o), '0);
    chk("R11", "irq", W'(irq_o), '0);
    rst = 1'b0;

    step(0, 1, 1, 0, 1, OP_NONE,  "R1");  // pin rises, captured, irq
    step(0, 1, 1, 0, 0, OP_ACK,   "R4");  // acknowledge clears flag
    step(0, 1, 1, 0, 1, OP_NONE,  "R8");  // pin falls in rising mode: ignored
    step(0, 1, 0, 0, 1, OP_NONE,  "R3");  // captured, enable low: no irq
    step(0, 0, 1, 0, 1, OP_NONE,  "R9");  // falling capture while flag set
    step(0, 1, 1, 1, 1, OP_NONE,  "R6");  // alt rises while pin selected: ignored
    step(0, 1, 1, 0, 0, OP_W1C0,  "R5");  // writing 0 keeps flag
    step(0, 1, 1, 0, 0, OP_W1C1,  "R5");  // writing 1 clears flag
    step(0, 1, 1, 0, 1, OP_NONE,  "R2");  // pin rises: value and flag together
    step(1, 0, 1, 1, 1, OP_NONE,  "R6");  // alt selected, alt falls: captured
    step(1, 1, 1, 0, 0, OP_CPUWR, "R7");  // CPU loads TOP value
    step(1, 1, 1, 0, 1, OP_NONE,  "R6");  // pin falls while alt selected: ignored
    step(1, 1, 1, 1, 1, OP_CPUWR, "R10"); // capture beats CPU write
    step(1, 0, 1, 1, 1, OP_ACK,   "R10"); // capture beats acknowledge
    step(1, 1, 1, 1, 1, OP_W1C1,  "R10"); // capture beats flag clear

    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) != 0), int'($urandom_range(0, 4)), "R1");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule